// File: doc/BRIEF.md
# Eight-Channel Wavetable Sample Sequencer

This block plays up to eight sampled waveforms out of one shared 64 KB byte memory by visiting the channels in turn. Each visit is a fixed run of twelve slots, and every slot is 4 x DIVIDER clocks long. Within a visit, the active channel does four things in order. It may reload its pointer. It reads one byte from memory. It adds its frequency step to a fixed-point pointer. Finally, it passes its current sample to a downstream mixer. One full pass over the eight channels forms one output frame. A pulse marks the start of each frame.

Each channel pointer is 27 bits wide and holds 11 fractional bits. A channel begins from an 8-bit start page. When it reads the marker byte 0xFF, it goes back to a 16-bit loop address. A channel does work only while the global sounding input is high and its own bit in the disable mask is low. The per-channel registers are loaded through a simple indexed write port. Address decode, stereo arithmetic and the memory itself all live outside this block.

Top module: `pcm_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, slot_idx and chan_idx are 0 and ram_rd_en, mix_valid and frame_pulse are 0. Every channel is in its start state with a zero pointer.
- R2: Each slot lasts 4 x DIVIDER clocks. slot_idx counts from 0 to 11. After slot 11, chan_idx steps by one and wraps from 7 to 0. frame_pulse is high for one clock as slot 0 of channel 0 begins, so frame pulses are 384 x DIVIDER clocks apart.
- R3: The first fetch that a channel makes after leaving the start state reads byte address {start_page, 8'h00}. That is the pointer loaded with the start register shifted left by 19.
- R4: Once per visit, the 16-bit step is added to the pointer modulo 2^27. The fetch address is pointer bits [26:11]. A step of 0x0800 moves one byte per visit, and a step of 0x0400 moves one byte every two visits.
- R5: A fetched byte of 0xFF leaves the channel's sample unchanged and puts the channel in loop state. The channel's next fetch reads the 16-bit loop address exactly.
- R6: mix_valid is high for one clock as slot 10 begins. During that clock mix_chan is the visited channel and mix_sample is the last non-0xFF byte that channel fetched.
- R7: While sounding is low, no fetch and no mix output occur and no pointer changes. When sounding returns high, each channel continues from its pointer as it was before.
- R8: A channel whose disable bit is set makes no fetch and gives no mix output. Channels whose bits are clear keep running.
- R9: When a channel's disable bit goes from 0 to 1, the channel returns to the start state. After the bit clears, the channel's next fetch is again at its start page.
- R10: The pointer wraps at 2^27, so the fetch address moves past 0xFFFF to low addresses.
- R11: ram_rd_en is high only in the first clock of slot 2, for one clock per processed visit. Slot 10 and every other slot issue no memory access.
- R12: Register writes use reg_sel: 0 = start page, 1 = loop address low byte, 2 = loop address high byte, 3 = step low byte, 4 = step high byte. The values 5 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sounding | input | 1 | Global playback enable |
| chan_disable | input | NUM_CH | Per-channel disable mask, 1 = channel off |
| reg_we | input | 1 | Register write strobe |
| reg_chan | input | CH_W | Channel that the write targets |
| reg_sel | input | 3 | Register select (see R12) |
| reg_wdata | input | 8 | Register write data |
| ram_rd_en | output | 1 | Sample memory read strobe |
| ram_addr | output | 16 | Sample memory byte address |
| ram_rdata | input | 8 | Read data, valid the clock after ram_rd_en |
| mix_valid | output | 1 | Sample hand-off strobe |
| mix_chan | output | CH_W | Channel of the handed-off sample |
| mix_sample | output | 8 | Handed-off sample byte |
| slot_idx | output | 4 | Current slot within the visit |
| chan_idx | output | CH_W | Channel being visited |
| frame_pulse | output | 1 | One-clock pulse at the start of each frame |

## Verification
Playback is run with a whole-byte step and a half-byte step, which shows that the fractional bits are carried and not dropped. A memory image with a planted 0xFF marker separates the loop jump from ordinary stepping, and it also shows that the previous sample is held. A near-maximum step taken from the top page checks the 27-bit wrap against a pointer model in the bench. Runs with sounding low, with one channel disabled next to a live one, and with a disable pulse show that gating freezes a pointer while a rising disable edge restarts it.

// File: rtl/pcm_seq_pkg.sv
package pcm_seq_pkg;
  localparam int SLOTS_PER_CH = 12;
  localparam int SLOT_W       = 4;
  localparam int PTR_W        = 27;
  localparam int FRAC_W       = 11;
  localparam int ADDR_W       = PTR_W - FRAC_W;
  localparam int DATA_W       = 8;

  localparam logic [SLOT_W-1:0] SLOT_RELOAD = 4'd1;
  localparam logic [SLOT_W-1:0] SLOT_FETCH  = 4'd2;
  localparam logic [SLOT_W-1:0] SLOT_STEP   = 4'd4;
  localparam logic [SLOT_W-1:0] SLOT_MIX    = 4'd9;

  localparam logic [DATA_W-1:0] LOOP_MARK = 8'hFF;

  typedef enum logic [1:0] {
    CH_START  = 2'd0,
    CH_NORMAL = 2'd1,
    CH_LOOP   = 2'd2
  } ch_state_e;

  typedef enum logic [2:0] {
    SEL_START   = 3'd0,
    SEL_LOOP_LO = 3'd1,
    SEL_LOOP_HI = 3'd2,
    SEL_STEP_LO = 3'd3,
    SEL_STEP_HI = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer #(
  parameter int DIVIDER = 1,
  parameter int NUM_CH  = 8,
  parameter int CH_W    = $clog2(NUM_CH)
) (
  input  logic                            clk,
  input  logic                            rst,
  output logic [pcm_seq_pkg::SLOT_W-1:0]  slot,
  output logic [CH_W-1:0]                 chan,
  output logic                            slot_end,
  output logic                            frame_pulse
);
  import pcm_seq_pkg::*;

  localparam int SLOT_CLKS = 4 * DIVIDER;
  localparam int TC_W      = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [TC_W-1:0]   TC_LAST   = TC_W'(SLOT_CLKS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS_PER_CH - 1);
  localparam logic [CH_W-1:0]   CH_LAST   = CH_W'(NUM_CH - 1);

  logic [TC_W-1:0] tc;

  assign slot_end = (tc == TC_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      tc          <= '0;
      slot        <= '0;
      chan        <= '0;
      frame_pulse <= 1'b0;
    end else begin
      frame_pulse <= 1'b0;
      if (slot_end) begin
        tc <= '0;
        if (slot == SLOT_LAST) begin
          slot <= '0;
          if (chan == CH_LAST) begin
            chan        <= '0;
            frame_pulse <= 1'b1;
          end else begin
            chan <= chan + 1'b1;
          end
        end else begin
          slot <= slot + 1'b1;
        end
      end else begin
        tc <= tc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_chan_regs.sv
module pcm_chan_regs #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CH_W-1:0]  wchan,
  input  logic [2:0]       wsel,
  input  logic [7:0]       wdata,
  output logic [7:0]       start_pg [NUM_CH],
  output logic [15:0]      loop_adr [NUM_CH],
  output logic [15:0]      step_val [NUM_CH]
);
  import pcm_seq_pkg::*;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        start_pg[i] <= '0;
        loop_adr[i] <= '0;
        step_val[i] <= '0;
      end else if (we && (wchan == CH_W'(i))) begin
        case (wsel)
          SEL_START:   start_pg[i]       <= wdata;
          SEL_LOOP_LO: loop_adr[i][7:0]  <= wdata;
          SEL_LOOP_HI: loop_adr[i][15:8] <= wdata;
          SEL_STEP_LO: step_val[i][7:0]  <= wdata;
          SEL_STEP_HI: step_val[i][15:8] <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pcm_chan_engine.sv
module pcm_chan_engine #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   sounding,
  input  logic [NUM_CH-1:0]                      chan_disable,
  input  logic [pcm_seq_pkg::SLOT_W-1:0]         slot,
  input  logic [CH_W-1:0]                        chan,
  input  logic                                   slot_end,
  input  logic [7:0]                             start_pg [NUM_CH],
  input  logic [15:0]                            loop_adr [NUM_CH],
  input  logic [15:0]                            step_val [NUM_CH],
  output logic                                   rd_en,
  output logic [pcm_seq_pkg::ADDR_W-1:0]         rd_addr,
  input  logic [pcm_seq_pkg::DATA_W-1:0]         rd_data,
  output logic                                   mix_valid,
  output logic [CH_W-1:0]                        mix_chan,
  output logic [pcm_seq_pkg::DATA_W-1:0]         mix_sample
);
  import pcm_seq_pkg::*;

  localparam int START_SH = PTR_W - 8;

  ch_state_e          state  [NUM_CH];
  logic [PTR_W-1:0]   ptr    [NUM_CH];
  logic [DATA_W-1:0]  sample [NUM_CH];
  logic [NUM_CH-1:0]  dis_q;
  logic               active;
  logic [PTR_W-1:0]   reload_ptr;

  assign active = sounding && !chan_disable[chan];

  always_comb begin
    case (state[chan])
      CH_START: reload_ptr = PTR_W'(start_pg[chan]) << START_SH;
      CH_LOOP:  reload_ptr = PTR_W'(loop_adr[chan]) << FRAC_W;
      default:  reload_ptr = ptr[chan];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) begin
        state[i]  <= CH_START;
        ptr[i]    <= '0;
        sample[i] <= '0;
      end
      dis_q      <= '0;
      rd_en      <= 1'b0;
      rd_addr    <= '0;
      mix_valid  <= 1'b0;
      mix_chan   <= '0;
      mix_sample <= '0;
    end else begin
      rd_en     <= 1'b0;
      mix_valid <= 1'b0;
      dis_q     <= chan_disable;
      if (slot_end && active) begin
        case (slot)
          SLOT_RELOAD: begin
            ptr[chan]   <= reload_ptr;
            state[chan] <= CH_NORMAL;
            rd_en       <= 1'b1;
            rd_addr     <= reload_ptr[PTR_W-1:FRAC_W];
          end
          SLOT_FETCH: begin
            if (rd_data == LOOP_MARK) state[chan]  <= CH_LOOP;
            else                      sample[chan] <= rd_data;
          end
          SLOT_STEP: ptr[chan] <= ptr[chan] + PTR_W'(step_val[chan]);
          SLOT_MIX: begin
            mix_valid  <= 1'b1;
            mix_chan   <= chan;
            mix_sample <= sample[chan];
          end
          default: ;
        endcase
      end
      for (int i = 0; i < NUM_CH; i++) begin
        if (chan_disable[i] && !dis_q[i]) state[i] <= CH_START;
      end
    end
  end
endmodule

// File: rtl/pcm_sequencer.sv
module pcm_sequencer #(
  parameter int DIVIDER = 1,
  parameter int NUM_CH  = 8,
  parameter int CH_W    = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sounding,
  input  logic [NUM_CH-1:0]  chan_disable,
  input  logic               reg_we,
  input  logic [CH_W-1:0]    reg_chan,
  input  logic [2:0]         reg_sel,
  input  logic [7:0]         reg_wdata,
  output logic               ram_rd_en,
  output logic [15:0]        ram_addr,
  input  logic [7:0]         ram_rdata,
  output logic               mix_valid,
  output logic [CH_W-1:0]    mix_chan,
  output logic [7:0]         mix_sample,
  output logic [3:0]         slot_idx,
  output logic [CH_W-1:0]    chan_idx,
  output logic               frame_pulse
);
  logic        slot_end;
  logic [7:0]  start_pg [NUM_CH];
  logic [15:0] loop_adr [NUM_CH];
  logic [15:0] step_val [NUM_CH];

  pcm_slot_timer #(.DIVIDER(DIVIDER), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_timer (
    .clk(clk), .rst(rst), .slot(slot_idx), .chan(chan_idx),
    .slot_end(slot_end), .frame_pulse(frame_pulse)
  );

  pcm_chan_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .wchan(reg_chan), .wsel(reg_sel),
    .wdata(reg_wdata), .start_pg(start_pg), .loop_adr(loop_adr),
    .step_val(step_val)
  );

  pcm_chan_engine #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_engine (
    .clk(clk), .rst(rst), .sounding(sounding), .chan_disable(chan_disable),
    .slot(slot_idx), .chan(chan_idx), .slot_end(slot_end),
    .start_pg(start_pg), .loop_adr(loop_adr), .step_val(step_val),
    .rd_en(ram_rd_en), .rd_addr(ram_addr), .rd_data(ram_rdata),
    .mix_valid(mix_valid), .mix_chan(mix_chan), .mix_sample(mix_sample)
  );
endmodule

// File: rtl/pcm_sequencer_chk.sv
module pcm_sequencer_chk #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst,
  input logic              sounding,
  input logic [NUM_CH-1:0] chan_disable,
  input logic              ram_rd_en,
  input logic              mix_valid,
  input logic [CH_W-1:0]   mix_chan,
  input logic [3:0]        slot_idx,
  input logic [CH_W-1:0]   chan_idx,
  input logic              frame_pulse
);
  p_rd_slot_r11: assert property (@(posedge clk) disable iff (rst)
    ram_rd_en |-> (slot_idx == 4'd2));

  p_rd_single_r11: assert property (@(posedge clk) disable iff (rst)
    ram_rd_en |=> !ram_rd_en);

  p_mix_slot_r6: assert property (@(posedge clk) disable iff (rst)
    mix_valid |-> (slot_idx == 4'd10) && (mix_chan == chan_idx));

  p_rd_gate_r7: assert property (@(posedge clk) disable iff (rst)
    ram_rd_en |-> $past(sounding) && !$past(chan_disable[chan_idx]));

  p_mix_gate_r8: assert property (@(posedge clk) disable iff (rst)
    mix_valid |-> $past(sounding) && !$past(chan_disable[mix_chan]));

  p_slot_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(slot_idx) |->
      (slot_idx == (($past(slot_idx) == 4'd11) ? 4'd0 : $past(slot_idx) + 4'd1)));

  p_chan_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_idx) |-> ($past(slot_idx) == 4'd11) && (slot_idx == 4'd0));

  p_frame_pos_r2: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |-> (slot_idx == 4'd0) && (chan_idx == '0));
endmodule

bind pcm_sequencer pcm_sequencer_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .sounding(sounding), .chan_disable(chan_disable),
  .ram_rd_en(ram_rd_en), .mix_valid(mix_valid), .mix_chan(mix_chan),
  .slot_idx(slot_idx), .chan_idx(chan_idx), .frame_pulse(frame_pulse)
);

// File: tb/tb_pcm_sequencer.sv
`timescale 1ns/1ps
module tb_pcm_sequencer;
  localparam int NUM_CH = 8;
  localparam int CH_W   = 3;
  localparam int FRAME  = 384;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sounding = 1'b0;
  logic [NUM_CH-1:0] chan_disable = '1;
  logic reg_we = 1'b0;
  logic [CH_W-1:0] reg_chan = '0;
  logic [2:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic ram_rd_en;
  logic [15:0] ram_addr;
  logic [7:0] ram_rdata = '0;
  logic mix_valid;
  logic [CH_W-1:0] mix_chan;
  logic [7:0] mix_sample;
  logic [3:0] slot_idx;
  logic [CH_W-1:0] chan_idx;
  logic frame_pulse;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit timed_out = 0;
  logic [7:0] mem [256];

  always #4 clk = ~clk;

  pcm_sequencer dut (
    .clk(clk), .rst(rst), .sounding(sounding), .chan_disable(chan_disable),
    .reg_we(reg_we), .reg_chan(reg_chan), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ram_rd_en(ram_rd_en), .ram_addr(ram_addr),
    .ram_rdata(ram_rdata), .mix_valid(mix_valid), .mix_chan(mix_chan),
    .mix_sample(mix_sample), .slot_idx(slot_idx), .chan_idx(chan_idx),
    .frame_pulse(frame_pulse)
  );

  always @(posedge clk) if (ram_rd_en) ram_rdata <= mem[ram_addr[7:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) timed_out <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int sel, input int val);
    @(negedge clk);
    reg_we = 1'b1; reg_chan = CH_W'(ch); reg_sel = 3'(sel); reg_wdata = 8'(val);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_fetch(input int ch, output int a);
    do @(negedge clk); while (!(ram_rd_en && chan_idx == CH_W'(ch)) && !timed_out);
    a = ram_addr;
  endtask

  task automatic wait_mix(input int ch, output int s);
    do @(negedge clk); while (!(mix_valid && mix_chan == CH_W'(ch)) && !timed_out);
    s = mix_sample;
  endtask

  task automatic restart(input int ch);
    do @(negedge clk); while (chan_idx != CH_W'((ch + 4) % NUM_CH) && !timed_out);
    chan_disable[ch] = 1'b1;
    repeat (5) @(negedge clk);
    chan_disable[ch] = 1'b0;
  endtask

  task automatic t_reset;
    chk(slot_idx == 0 && chan_idx == 0, "R1 counters", {slot_idx, 1'b0, chan_idx}, 0);
    chk(!ram_rd_en && !mix_valid && !frame_pulse, "R1 strobes",
        {ram_rd_en, mix_valid, frame_pulse}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(slot_idx == 0 && !ram_rd_en && !frame_pulse, "R1 after release",
        {slot_idx, ram_rd_en}, 0);
  endtask

  task automatic t_schedule;
    int n;
    int prev;
    do @(negedge clk); while (!frame_pulse && !timed_out);
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_pulse && !timed_out);
    chk(n == FRAME, "R2 frame period", n, FRAME);
    do @(negedge clk); while (slot_idx != 3 && !timed_out);
    n = 0;
    while (slot_idx == 3 && !timed_out) begin @(negedge clk); n++; end
    chk(n == 4, "R2 slot length", n, 4);
    for (int k = 0; k < NUM_CH; k++) begin
      prev = chan_idx;
      do @(negedge clk); while (chan_idx == CH_W'(prev) && !timed_out);
      chk(chan_idx == CH_W'((prev + 1) % NUM_CH) && slot_idx == 0, "R2 channel order",
          chan_idx, (prev + 1) % NUM_CH);
    end
  endtask

  task automatic t_start_step;
    int a, s;
    wr(0, 0, 8'h12); wr(0, 1, 8'h34); wr(0, 2, 8'h12);
    wr(0, 3, 8'h00); wr(0, 4, 8'h08);
    wr(0, 5, 8'hAA); wr(0, 6, 8'hBB); wr(0, 7, 8'hCC);
    sounding = 1'b1;
    chan_disable = 8'hFE;
    for (int k = 0; k < 3; k++) begin
      wait_fetch(0, a);
      chk(a == 16'h1200 + k, (k == 0) ? "R3 start page (R12 sel 5-7 ignored)" : "R4 whole step",
          a, 16'h1200 + k);
      wait_mix(0, s);
      chk(s == k, "R6 mix sample", s, k);
    end
  endtask

  task automatic t_loop;
    int a, s;
    mem[3] = 8'hFF;
    restart(0);
    for (int k = 0; k < 4; k++) begin
      wait_fetch(0, a);
      chk(a == 16'h1200 + k, "R9 restart walk", a, 16'h1200 + k);
      wait_mix(0, s);
      chk(s == ((k == 3) ? 2 : k), "R5 sample held on marker", s, (k == 3) ? 2 : k);
    end
    wait_fetch(0, a);
    chk(a == 16'h1234, "R5 loop address", a, 16'h1234);
    wait_mix(0, s);
    chk(s == 8'h34, "R5 sample after loop", s, 8'h34);
    mem[3] = 8'h03;
  endtask

  task automatic t_sounding;
    int rd, mx, fp, a;
    @(negedge clk); sounding = 1'b0;
    rd = 0; mx = 0; fp = 0;
    repeat (2 * FRAME) begin
      @(negedge clk);
      rd += int'(ram_rd_en); mx += int'(mix_valid); fp += int'(frame_pulse);
    end
    chk(rd == 0 && mx == 0, "R7 silent while not sounding", rd + mx, 0);
    chk(fp == 2, "R2 frames continue while silent", fp, 2);
    sounding = 1'b1;
    wait_fetch(0, a);
    chk(a == 16'h1235, "R7 pointer kept", a, 16'h1235);
  endtask

  task automatic t_disable;
    int a, r0, r1;
    wr(1, 0, 8'h20); wr(1, 3, 8'h00); wr(1, 4, 8'h04);
    chan_disable = 8'hFC;
    for (int k = 0; k < 4; k++) begin
      wait_fetch(1, a);
      chk(a == 16'h2000 + k / 2, "R4 half step", a, 16'h2000 + k / 2);
    end
    @(negedge clk); chan_disable = 8'hFE;
    r0 = 0; r1 = 0;
    repeat (2 * FRAME) begin
      @(negedge clk);
      if (ram_rd_en && chan_idx == 0) r0++;
      if ((ram_rd_en && chan_idx == 1) || (mix_valid && mix_chan == 1)) r1++;
    end
    chk(r1 == 0, "R8 disabled channel silent", r1, 0);
    chk(r0 == 2, "R8 other channel runs", r0, 2);
    restart(0);
    wait_fetch(0, a);
    chk(a == 16'h1200, "R9 restart at start page", a, 16'h1200);
  endtask

  task automatic t_wrap;
    int a, bad_rd;
    bit wrapped;
    logic [26:0] p;
    wr(2, 0, 8'hFF); wr(2, 3, 8'hFF); wr(2, 4, 8'hFF);
    chan_disable = 8'hFA;
    p = 27'hFF << 19;
    wrapped = 0;
    bad_rd = 0;
    for (int k = 0; k < 12; k++) begin
      wait_fetch(2, a);
      chk(a == int'(p[26:11]), "R10 wrap model", a, p[26:11]);
      if (k > 0 && p[26:11] < 16'hFF00) wrapped = 1;
      if (slot_idx != 2) bad_rd++;
      p = p + 27'hFFFF;
    end
    chk(wrapped, "R10 address wrapped", wrapped, 1);
    chk(bad_rd == 0, "R11 read only in slot 2", bad_rd, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i & 8'h7F);
    repeat (3) @(negedge clk);
    t_reset();
    t_schedule();
    t_start_step();
    t_loop();
    t_sounding();
    t_disable();
    t_wrap();
    if (timed_out) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule